// File: doc/BRIEF.md
# Dual-Port Two-Way Data Cache

This block is a two-way set-associative data cache placed between a processor core that issues data accesses on two independent 64-bit ports (A and B) and a slower next-level memory. In a single cycle, each port may present either a load or a store. Each port does its own tag compare against one shared tag, valid, dirty and LRU store. When every presented access hits, both ports complete in the cycle they were presented. Load data is returned combinationally in that same cycle, and stores are written at the closing clock edge.

On any miss, the cache fills one line at a time over a simple request/acknowledge memory interface. Each transaction carries one 64-bit word. Before the refill, the cache writes back the victim line if it is dirty. Stores are write-back and write-allocate. A request is held until its port's ready goes high, and only a port that presented a request can see ready. The parameters set the set count and the line length. With SETS=256 and LINE_WORDS=4, the cache holds 16 KB. The default is smaller so that simulation stays fast.

Address layout, byte addressed: bits [2:0] are ignored because accesses are 64-bit aligned. The next log2(LINE_WORDS) bits select the word within a line. The next log2(SETS) bits select the set. The remaining upper bits form the tag.

Top module: `dcache_dual`

## Requirements
- R1: After reset no line is valid, `mem_req` is low, and neither ready is high. Because no line is valid, the first access to any address misses.
- R2: A load miss reads the whole line from memory, LINE_WORDS word transactions in ascending word order, and returns the addressed word. Later accesses to that line complete in the cycle they are presented and cause no memory traffic.
- R3: A store that hits updates only the cache, and memory is not written. A later load from either port returns the stored value.
- R4: When the victim line is dirty, all of its words are written to memory before the new line is read, and the refill read starts at word 0. When the victim line is clean, nothing is written.
- R5: A miss replaces the least-recently-used way of its set. A hit or a refill makes the touched way most recently used. An address is present in at most one way.
- R6: When both ports hit the same set in one cycle, the way touched by port B becomes the most recently used.
- R7: When both ports miss, port A's line is fetched first. Neither port is ready while any presented access misses or while a refill is running, so both ports then complete in the same cycle.
- R8: When both ports store to the same 64-bit word in one cycle, port B's data is kept.
- R9: When one port loads a word that the other port stores in the same cycle, the load returns the contents the word had before the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_req | input | 1 | Port A access request, held until a_ready |
| a_we | input | 1 | Port A store (1) or load (0) |
| a_addr | input | ADDR_W | Port A byte address |
| a_wdata | input | 64 | Port A store data |
| a_rdata | output | 64 | Port A load data, valid while a_ready |
| a_ready | output | 1 | Port A access completes this cycle |
| b_req | input | 1 | Port B access request, held until b_ready |
| b_we | input | 1 | Port B store (1) or load (0) |
| b_addr | input | ADDR_W | Port B byte address |
| b_wdata | input | 64 | Port B store data |
| b_rdata | output | 64 | Port B load data, valid while b_ready |
| b_ready | output | 1 | Port B access completes this cycle |
| mem_req | output | 1 | Memory word transaction request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory word byte address |
| mem_wdata | output | 64 | Write-back data |
| mem_ack | input | 1 | Transaction accepted at this clock edge |
| mem_rdata | input | 64 | Read data, valid with mem_ack |

## Verification
The hardest situation to reach from the ports is a replacement decision that depends on a same-cycle update from both ports. This happens when both ports hit the same set in one cycle, and the next miss in that set then has to evict port A's line.

The stimulus builds this case in stages. First, a dual miss loads two lines into both ways of one set, and the order of the memory reads shows which port was served first. Next, a single cycle with both ports hitting those two lines sets the LRU state. A third line in the same set then forces an eviction. Finally, the bench tells which line survived by timing each port's completion and counting the memory reads.

Dirty eviction is reached in a similar way. A store miss allocates a line, and two further misses in the same set push it out. The written-back words are then compared in the bench's memory model.

// File: rtl/dc_pkg.sv
// Shared definitions for the dual-port data cache.
package dc_pkg;
    localparam int WORD_W = 64;

    // Refill engine states
    typedef enum logic [1:0] {
        RF_IDLE,
        RF_WB,
        RF_FILL
    } rf_state_e;
endpackage

// File: rtl/dc_lookup.sv
// Per-port tag compare against both ways of one set.
// Assumes tags and valid bits are already read for the addressed set.
module dc_lookup #(
    parameter int TAG_W = 24
) (
    input  logic [TAG_W-1:0] tag_in,
    input  logic [TAG_W-1:0] tag_w0,
    input  logic [TAG_W-1:0] tag_w1,
    input  logic [1:0]       valid,
    output logic [1:0]       match
);
    // Compare the requested tag with each valid way
    always_comb begin
        match[0] = valid[0] && (tag_w0 == tag_in);
        match[1] = valid[1] && (tag_w1 == tag_in);
    end
endmodule

// File: rtl/dc_refill.sv
// Miss engine: writes back a dirty victim word by word, then reads the new line.
// Assumes one 64-bit word per memory transaction, accepted when mem_ack is high.
module dc_refill
    import dc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 24,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  st_idx,
    input  logic [TAG_W-1:0]  st_tag,
    input  logic              st_way,
    input  logic [TAG_W-1:0]  st_vtag,
    input  logic              st_vdirty,
    input  logic              mem_ack,
    output logic              idle,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [IDX_W-1:0]  f_idx,
    output logic              f_way,
    output logic [OFF_W-1:0]  f_word,
    output logic              fill_we,
    output logic              fill_done
);
    localparam logic [OFF_W-1:0] LAST = OFF_W'((1 << OFF_W) - 1);

    rf_state_e        state_q;
    logic [OFF_W-1:0] cnt_q;
    logic [TAG_W-1:0] tag_q, vtag_q;

    // Sequence write-back and fill word transactions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RF_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                RF_IDLE: if (start) begin
                    f_idx   <= st_idx;
                    f_way   <= st_way;
                    tag_q   <= st_tag;
                    vtag_q  <= st_vtag;
                    cnt_q   <= '0;
                    state_q <= st_vdirty ? RF_WB : RF_FILL;
                end
                RF_WB: if (mem_ack) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= RF_FILL;
                end
                RF_FILL: if (mem_ack) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= RF_IDLE;
                end
                default: state_q <= RF_IDLE;
            endcase
        end
    end

    // Drive the memory interface and the array write strobes
    always_comb begin
        idle      = (state_q == RF_IDLE);
        mem_req   = !idle;
        mem_we    = (state_q == RF_WB);
        mem_addr  = {(mem_we ? vtag_q : tag_q), f_idx, cnt_q, 3'b000};
        f_word    = cnt_q;
        fill_we   = (state_q == RF_FILL) && mem_ack;
        fill_done = fill_we && (cnt_q == LAST);
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2
    AST_FILL_FROM_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && $past(mem_req && mem_we) |-> f_word == '0); // R4
endmodule

// File: rtl/dcache_dual.sv
// Two-way set-associative write-back data cache with two 64-bit access ports.
// Assumes aligned 64-bit accesses and requests held until ready; LINE_WORDS >= 2.
module dcache_dual
    import dc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 8,
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [63:0]       a_wdata,
    output logic [63:0]       a_rdata,
    output logic              a_ready,
    input  logic              b_req,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [63:0]       b_wdata,
    output logic [63:0]       b_rdata,
    output logic              b_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [63:0]       mem_rdata
);
    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - 3 - OFF_W - IDX_W;

    logic [TAG_W-1:0]  tag_q  [SETS][2];
    logic [1:0]        valid_q [SETS];
    logic [1:0]        dirty_q [SETS];
    logic [SETS-1:0]   lru_q;              // way to replace next
    logic [WORD_W-1:0] data_q [SETS][2][LINE_WORDS];

    logic [1:0]              p_req, p_we, p_hit, p_way, p_miss, p_ready;
    logic [ADDR_W-1:0]       p_addr  [2];
    logic [WORD_W-1:0]       p_wdata [2];
    logic [WORD_W-1:0]       p_rdata [2];
    logic [IDX_W-1:0]        idx     [2];
    logic [TAG_W-1:0]        tg      [2];
    logic [OFF_W-1:0]        wo      [2];
    logic [1:0]              match   [2];

    logic              idle, start, sel, fill_we, fill_done, f_way;
    logic [IDX_W-1:0]  f_idx;
    logic [OFF_W-1:0]  f_word;

    // Gather both ports into indexed form
    always_comb begin
        p_req = {b_req, a_req};
        p_we  = {b_we, a_we};
        p_addr[0]  = a_addr;   p_addr[1]  = b_addr;
        p_wdata[0] = a_wdata;  p_wdata[1] = b_wdata;
    end

    for (genvar p = 0; p < 2; p++) begin : g_port
        // Split the address and look the port up in its set
        always_comb begin
            idx[p] = p_addr[p][3+OFF_W +: IDX_W];
            tg[p]  = p_addr[p][ADDR_W-1 -: TAG_W];
            wo[p]  = p_addr[p][3 +: OFF_W];
        end

        dc_lookup #(.TAG_W(TAG_W)) u_lookup (
            .tag_in (tg[p]),
            .tag_w0 (tag_q[idx[p]][0]),
            .tag_w1 (tag_q[idx[p]][1]),
            .valid  (valid_q[idx[p]]),
            .match  (match[p])
        );

        // Hit, miss and completion for this port
        always_comb begin
            p_hit[p]   = |match[p];
            p_way[p]   = match[p][1];
            p_miss[p]  = p_req[p] && !p_hit[p];
            p_rdata[p] = data_q[idx[p]][p_way[p]][wo[p]];
        end

        AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            p_req[p] |-> $onehot0(match[p])); // R5
    end

    // Complete accesses only when nothing presented misses and no refill runs
    always_comb begin
        p_ready = {2{idle && !(|p_miss)}} & p_req;
        start   = idle && (|p_miss);
        sel     = !p_miss[0];
        a_ready = p_ready[0];
        b_ready = p_ready[1];
        a_rdata = p_rdata[0];
        b_rdata = p_rdata[1];
    end

    dc_refill #(
        .ADDR_W(ADDR_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_refill (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .st_idx    (idx[sel]),
        .st_tag    (tg[sel]),
        .st_way    (lru_q[idx[sel]]),
        .st_vtag   (tag_q[idx[sel]][lru_q[idx[sel]]]),
        .st_vdirty (valid_q[idx[sel]][lru_q[idx[sel]]] && dirty_q[idx[sel]][lru_q[idx[sel]]]),
        .mem_ack   (mem_ack),
        .idle      (idle),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .f_idx     (f_idx),
        .f_way     (f_way),
        .f_word    (f_word),
        .fill_we   (fill_we),
        .fill_done (fill_done)
    );

    // Victim word for write-back
    assign mem_wdata = data_q[f_idx][f_way][f_word];

    // Line state: valid, dirty, tag and LRU; port B applied after port A
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
            lru_q <= '0;
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (p_ready[p]) begin
                    lru_q[idx[p]] <= !p_way[p];
                    if (p_we[p]) dirty_q[idx[p]][p_way[p]] <= 1'b1;
                end
            end
            if (fill_done) begin
                valid_q[f_idx][f_way] <= 1'b1;
                dirty_q[f_idx][f_way] <= 1'b0;
                tag_q[f_idx][f_way]   <= mem_addr[ADDR_W-1 -: TAG_W];
                lru_q[f_idx]          <= !f_way;
            end
        end
    end

    // Data words: port stores in order A then B, refill words from memory
    always_ff @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (p_ready[p] && p_we[p]) data_q[idx[p]][p_way[p]][wo[p]] <= p_wdata[p];
        end
        if (fill_we) data_q[f_idx][f_way][f_word] <= mem_rdata;
    end

    AST_STALL_ON_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !a_ready && !b_ready); // R7
    AST_B_WAY_MRU: assert property (@(posedge clk) disable iff (!rst_n)
        a_ready && b_ready && idx[0] == idx[1] |=> lru_q[$past(idx[1])] == !$past(p_way[1])); // R6
    AST_FILL_MRU: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> lru_q[$past(f_idx)] == !$past(f_way) && valid_q[$past(f_idx)][$past(f_way)]); // R5
endmodule

// File: tb/tb_dcache_dual.sv
`timescale 1ns/1ps
module tb_dcache_dual;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_req = 0, a_we = 0, b_req = 0, b_we = 0;
    logic [31:0] a_addr = 0, b_addr = 0;
    logic [63:0] a_wdata = 0, b_wdata = 0;
    logic [63:0] a_rdata, b_rdata, mem_wdata;
    logic        a_ready, b_ready, mem_req, mem_we;
    logic [31:0] mem_addr;
    logic        mem_ack = 0;
    logic [63:0] mem_rdata = 0;

    int checks = 0, errors = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [31:0] first_rd;
    bit          first_seen;
    logic [63:0] mem [logic [28:0]];

    always #2.5 clk = ~clk;

    dcache_dual dut (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_ready(a_ready),
        .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_ready(b_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [63:0] init_word(logic [31:0] a);
        return {a ^ 32'h5A5A_0000, ~a};
    endfunction

    function automatic logic [63:0] mem_rd(logic [31:0] a);
        if (mem.exists(a[31:3])) return mem[a[31:3]];
        return init_word({a[31:3], 3'b000});
    endfunction

    // Next-level memory model: acknowledges each word one cycle after request
    always @(negedge clk) begin
        if (!rst_n) mem_ack = 1'b0;
        else if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                mem[mem_addr[31:3]] = mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata = mem_rd(mem_addr);
                rd_cnt++;
                if (!first_seen) begin first_rd = mem_addr; first_seen = 1; end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one access per enabled port and wait for each to complete
    task automatic access(input bit ea, input bit wa, input logic [31:0] ada, input logic [63:0] da,
                          input bit eb, input bit wb, input logic [31:0] adb, input logic [63:0] db,
                          output logic [63:0] qa, output logic [63:0] qb,
                          output int lata, output int latb);
        bit pa, pb;
        int n = 0;
        @(negedge clk);
        a_req = ea; a_we = wa; a_addr = ada; a_wdata = da;
        b_req = eb; b_we = wb; b_addr = adb; b_wdata = db;
        pa = ea; pb = eb; qa = '0; qb = '0; lata = 0; latb = 0;
        while (pa || pb) begin
            #1;
            n++;
            if (pa && a_ready) begin qa = a_rdata; lata = n; pa = 0; end
            if (pb && b_ready) begin qb = b_rdata; latb = n; pb = 0; end
            @(negedge clk);
            if (!pa) a_req = 0;
            if (!pb) b_req = 0;
        end
    endtask

    task automatic ld(input logic [31:0] ad, output logic [63:0] q, output int lat);
        logic [63:0] qb; int lb;
        access(1, 0, ad, 0, 0, 0, 0, 0, q, qb, lat, lb);
    endtask

    task automatic st(input logic [31:0] ad, input logic [63:0] d);
        logic [63:0] q, qb; int l, lb;
        access(1, 1, ad, d, 0, 0, 0, 0, q, qb, l, lb);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!a_ready && !b_ready && !mem_req, "R1 idle after reset",
            {a_ready, b_ready, mem_req}, 0);
    endtask

    task automatic t_load_fill;
        logic [63:0] q; int lat, r0, w0;
        r0 = rd_cnt; w0 = wr_cnt; first_seen = 0;
        ld(32'h1008, q, lat);
        chk(q == init_word(32'h1008), "R2 miss data", q, init_word(32'h1008));
        chk(rd_cnt - r0 == 4 && wr_cnt == w0, "R2 line read count", rd_cnt - r0, 4);
        chk(first_rd == 32'h1000, "R2 fill starts at word 0", first_rd, 32'h1000);
        chk(lat > 1, "R1 first access misses", lat, 2);
        ld(32'h1010, q, lat);
        chk(q == init_word(32'h1010) && lat == 1, "R2 hit same cycle", {q[31:0], 32'(lat)},
            {init_word(32'h1010) >> 0}[31:0] << 32 | 64'd1);
        chk(rd_cnt - r0 == 4, "R2 hit without traffic", rd_cnt - r0, 4);
    endtask

    task automatic t_store_hit;
        logic [63:0] qa, qb; int la, lb, w0;
        w0 = wr_cnt;
        st(32'h1018, 64'hDEAD_BEEF_0000_1111);
        chk(wr_cnt == w0, "R3 store not written through", wr_cnt - w0, 0);
        access(0, 0, 0, 0, 1, 0, 32'h1018, 0, qa, qb, la, lb);
        chk(qb == 64'hDEAD_BEEF_0000_1111, "R3 store visible on B", qb, 64'hDEAD_BEEF_0000_1111);
        chk(mem_rd(32'h1018) == init_word(32'h1018), "R3 memory untouched",
            mem_rd(32'h1018), init_word(32'h1018));
    endtask

    task automatic t_rw_same_word;
        logic [63:0] qa, qb; int la, lb;
        access(1, 1, 32'h1010, 64'h1234_5678_9ABC_DEF0, 1, 0, 32'h1010, 0, qa, qb, la, lb);
        chk(qb == init_word(32'h1010), "R9 load sees old value", qb, init_word(32'h1010));
        ld(32'h1010, qa, la);
        chk(qa == 64'h1234_5678_9ABC_DEF0, "R9 store landed", qa, 64'h1234_5678_9ABC_DEF0);
    endtask

    task automatic t_both_store;
        logic [63:0] qa, qb; int la, lb;
        access(1, 1, 32'h1000, 64'hAAAA_AAAA_AAAA_AAAA, 1, 1, 32'h1000, 64'hBBBB_BBBB_BBBB_BBBB,
               qa, qb, la, lb);
        ld(32'h1000, qa, la);
        chk(qa == 64'hBBBB_BBBB_BBBB_BBBB, "R8 port B store wins", qa, 64'hBBBB_BBBB_BBBB_BBBB);
    endtask

    task automatic t_dual_miss_and_lru_b;
        logic [63:0] qa, qb; int la, lb, r0, w0;
        r0 = rd_cnt; first_seen = 0;
        access(1, 0, 32'h2040, 0, 1, 0, 32'h2140, 0, qa, qb, la, lb);
        chk(first_rd == 32'h2040, "R7 port A line first", first_rd, 32'h2040);
        chk(qa == init_word(32'h2040) && qb == init_word(32'h2140), "R7 both data",
            qa ^ qb, init_word(32'h2040) ^ init_word(32'h2140));
        chk(la == lb && rd_cnt - r0 == 8, "R7 joint completion", la, lb);
        // same-set dual hit: way of B becomes most recent, A's line is victim
        access(1, 0, 32'h2040, 0, 1, 0, 32'h2140, 0, qa, qb, la, lb);
        chk(la == 1 && lb == 1, "R6 dual hit same cycle", la, 1);
        w0 = wr_cnt;
        ld(32'h2240, qa, la);
        chk(wr_cnt == w0, "R4 clean victim not written", wr_cnt - w0, 0);
        ld(32'h2140, qa, la);
        chk(la == 1, "R6 port B line kept", la, 1);
        r0 = rd_cnt;
        ld(32'h2040, qa, la);
        chk(rd_cnt - r0 == 4 && qa == init_word(32'h2040), "R6 port A line evicted", rd_cnt - r0, 4);
    endtask

    task automatic t_lru_single;
        logic [63:0] q; int lat, r0;
        ld(32'h3080, q, lat);
        ld(32'h3180, q, lat);
        ld(32'h3080, q, lat);
        ld(32'h3280, q, lat);
        ld(32'h3080, q, lat);
        chk(lat == 1, "R5 recently used line kept", lat, 1);
        r0 = rd_cnt;
        ld(32'h3180, q, lat);
        chk(rd_cnt - r0 == 4, "R5 least recent line replaced", rd_cnt - r0, 4);
    endtask

    task automatic t_writeback;
        logic [63:0] q; int lat, r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        st(32'h40C0, 64'h5555_6666_7777_8888);
        chk(rd_cnt - r0 == 4 && wr_cnt == w0, "R3 store miss allocates", rd_cnt - r0, 4);
        ld(32'h41C0, q, lat);
        w0 = wr_cnt;
        ld(32'h42C0, q, lat);
        chk(wr_cnt - w0 == 4, "R4 dirty victim written back", wr_cnt - w0, 4);
        chk(mem_rd(32'h40C0) == 64'h5555_6666_7777_8888, "R4 stored word in memory",
            mem_rd(32'h40C0), 64'h5555_6666_7777_8888);
        chk(mem_rd(32'h40C8) == init_word(32'h40C8), "R4 other words written back",
            mem_rd(32'h40C8), init_word(32'h40C8));
        ld(32'h40C0, q, lat);
        chk(q == 64'h5555_6666_7777_8888, "R4 reload after write-back", q, 64'h5555_6666_7777_8888);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_load_fill();
        t_store_hit();
        t_rw_same_word();
        t_both_store();
        t_dual_miss_and_lru_b();
        t_lru_single();
        t_writeback();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule